// File: doc/BRIEF.md
# Dual-Clock FIFO with Encoded Occupancy Flags

This block is a first-in first-out buffer for 9-bit words. A producer and a consumer each have their own free-running clock. The two clocks may be unrelated, or they may be tied to one net. A word enters on every write-clock rising edge while the write enable is high. A word leaves on every read-clock rising edge while the read enable is high. Words pass through a registered input stage on the write side and a registered output on the read side. The write and read pointers cross between the two domains as Gray code through two-flop synchronisers.

Fill level is reported as a 2-bit code rather than as separate full and empty pins. The read domain works out the low-side states (empty, nearly empty, middle) from its own view of the pointers. The write domain works out the high-side state (nearly full). When the high-side state is set, it takes priority on the code.

An optional parity feature works on bit 8 of each word. On the write side it can replace bit 8 with the even parity of bits 7:0. On the read side it can flag words whose total parity is odd. An asynchronous active-low master reset empties the buffer.

Top module: `fifo_dc`

## Requirements
- R1: While the master reset is low and after it is released, the occupancy code is 00, the parity error output is 0 and the read data is 0.
- R2: A write enable held for N consecutive write-clock edges stores N words, and they are read back in the same order.
- R3: A write made when DEPTH words are held is ignored: later reads return only the first DEPTH words, and then the code returns to 00.
- R4: A read made while empty is ignored: the read data holds its last value, and the next word written is the next word read.
- R5: occ_code is 00 (empty) when the read domain sees zero words.
- R6: occ_code is 01 (nearly empty) when 1 to AE_TH words are held.
- R7: occ_code is 10 (middle) when more than AE_TH and fewer than DEPTH-AF_TH words are held.
- R8: occ_code is 11 (nearly full) when at least DEPTH-AF_TH words are held, and this takes priority over the low-side states.
- R9: With par_gen high at the write edge, the stored bit 8 is the XOR of bits 7:0, so the stored 9-bit word has even parity. With par_gen low, all 9 bits are stored as given.
- R10: On each accepted read, par_err becomes par_chk AND (XOR of all 9 bits of the word read). It updates in the same cycle as rdata.
- R11: With unrelated read and write clock periods and reads and writes running at the same time, the order and values of the words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Asynchronous active-low master reset |
| wen | input | 1 | Write enable, sampled on wclk |
| wdata | input | 9 | Write data |
| par_gen | input | 1 | Replace bit 8 with the even parity of bits 7:0 on write |
| ren | input | 1 | Read enable, sampled on rclk |
| par_chk | input | 1 | Enable the parity check on read |
| rdata | output | 9 | Registered read data |
| par_err | output | 1 | Registered parity error for the last word read |
| occ_code | output | 2 | Occupancy code: 00 empty, 01 nearly empty, 10 middle, 11 nearly full |

## Verification
The pointer assertions assume that mrst_n is held low long enough for both clocks to see it. They also assume that the enables change only away from their own clock edge. The bench drives every input on the falling edge of its own clock. It changes the clock mode only while reset is held. The Gray-step check assumes the write pointer moves by at most one per write cycle, which holds because one word at most is committed per edge. The bench lets the pointers settle for several cycles before it samples the flags, because the flags depend on synchroniser lag.

// File: rtl/fifo_dc_pkg.sv
package fifo_dc_pkg;

  typedef enum logic [1:0] {
    OCC_EMPTY = 2'b00,
    OCC_LOW   = 2'b01,
    OCC_MID   = 2'b10,
    OCC_HIGH  = 2'b11
  } occ_e;

  function automatic logic even_bit(input logic [7:0] b);
    return ^b;
  endfunction

  function automatic occ_e low_side_class(input int lvl, input int ae_th);
    if (lvl == 0)          return OCC_EMPTY;
    else if (lvl <= ae_th) return OCC_LOW;
    else                   return OCC_MID;
  endfunction

  function automatic logic high_side_test(input int lvl, input int depth, input int af_th);
    return lvl >= (depth - af_th);
  endfunction

endpackage

// File: rtl/fifo_dc_gsync.sv
module fifo_dc_gsync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fifo_dc_wr.sv
module fifo_dc_wr
  import fifo_dc_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AF_TH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic [8:0]    wdata,
  input  logic          par_gen,
  input  logic [PW-1:0] rgray_s,
  output logic          wr_commit,
  output logic          wr_full,
  output logic [AW-1:0] mem_waddr,
  output logic [8:0]    mem_wdata,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic          af
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          wen_q;
  logic [8:0]    din_q;
  logic [PW-1:0] rbin_s, level, wbin_nx;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q <= 1'b0;
      din_q <= '0;
    end else begin
      wen_q <= wen;
      din_q <= par_gen ? {even_bit(wdata[7:0]), wdata[7:0]} : wdata;
    end
  end

  assign rbin_s    = from_gray(rgray_s);
  assign level     = wbin - rbin_s;
  assign wr_full   = (level == PW'(DEPTH));
  assign wr_commit = wen_q & ~wr_full;
  assign wbin_nx   = wbin + PW'(wr_commit);
  assign mem_waddr = wbin[AW-1:0];
  assign mem_wdata = din_q;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      af    <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= to_gray(wbin_nx);
      af    <= high_side_test(int'(wbin_nx - rbin_s), DEPTH, AF_TH);
    end
  end
endmodule

// File: rtl/fifo_dc_rd.sv
module fifo_dc_rd
  import fifo_dc_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AE_TH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ren,
  input  logic          par_chk,
  input  logic [PW-1:0] wgray_s,
  input  logic [8:0]    mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic          rd_fire,
  output logic          rd_empty,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic [8:0]    rdata,
  output logic          par_err,
  output occ_e          low_state
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin_s, rbin_nx;

  assign wbin_s    = from_gray(wgray_s);
  assign rd_empty  = (wbin_s == rbin);
  assign rd_fire   = ren & ~rd_empty;
  assign rbin_nx   = rbin + PW'(rd_fire);
  assign mem_raddr = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      rdata     <= '0;
      par_err   <= 1'b0;
      low_state <= OCC_EMPTY;
    end else begin
      rbin      <= rbin_nx;
      rgray     <= to_gray(rbin_nx);
      low_state <= low_side_class(int'(wbin_s - rbin_nx), AE_TH);
      if (rd_fire) begin
        rdata   <= mem_rdata;
        par_err <= par_chk & (^mem_rdata);
      end
    end
  end
endmodule

// File: rtl/fifo_dc.sv
module fifo_dc
  import fifo_dc_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AE_TH = 8,
  parameter int AF_TH = 8
) (
  input  logic       wclk,
  input  logic       rclk,
  input  logic       mrst_n,
  input  logic       wen,
  input  logic [8:0] wdata,
  input  logic       par_gen,
  input  logic       ren,
  input  logic       par_chk,
  output logic [8:0] rdata,
  output logic       par_err,
  output logic [1:0] occ_code
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [8:0]    mem [DEPTH];
  logic          wr_commit, wr_full, af, rd_fire, rd_empty;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [8:0]    mem_wdata, mem_rdata;
  logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  occ_e          low_state;

  fifo_dc_wr #(.DEPTH(DEPTH), .AF_TH(AF_TH), .AW(AW), .PW(PW)) u_wr (
    .wclk(wclk), .rst_n(mrst_n), .wen(wen), .wdata(wdata), .par_gen(par_gen),
    .rgray_s(rgray_s), .wr_commit(wr_commit), .wr_full(wr_full),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .wbin(wbin), .wgray(wgray), .af(af)
  );

  fifo_dc_rd #(.DEPTH(DEPTH), .AE_TH(AE_TH), .AW(AW), .PW(PW)) u_rd (
    .rclk(rclk), .rst_n(mrst_n), .ren(ren), .par_chk(par_chk), .wgray_s(wgray_s),
    .mem_rdata(mem_rdata), .mem_raddr(mem_raddr), .rd_fire(rd_fire),
    .rd_empty(rd_empty), .rbin(rbin), .rgray(rgray), .rdata(rdata),
    .par_err(par_err), .low_state(low_state)
  );

  for (genvar dir = 0; dir < 2; dir++) begin : g_cross
    if (dir == 0) begin : g_w2r
      fifo_dc_gsync #(.W(PW)) u_sync (.clk(rclk), .rst_n(mrst_n), .d(wgray), .q(wgray_s));
    end else begin : g_r2w
      fifo_dc_gsync #(.W(PW)) u_sync (.clk(wclk), .rst_n(mrst_n), .d(rgray), .q(rgray_s));
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_commit) mem[mem_waddr] <= mem_wdata;
  end
  assign mem_rdata = mem[mem_raddr];

  assign occ_code = af ? OCC_HIGH : low_state;
endmodule

// File: rtl/fifo_dc_chk.sv
module fifo_dc_chk #(
  parameter int PW = 10
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst_n,
  input logic          wr_commit,
  input logic          rd_fire,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] rgray
);
  p_wptr_step_r2: assert property (@(posedge wclk) disable iff (!mrst_n)
    wr_commit |=> (wbin == $past(wbin) + PW'(1)));

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!mrst_n)
    !wr_commit |=> $stable(wbin));

  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!mrst_n)
    !rd_fire |=> $stable(rbin));

  p_rptr_step_r11: assert property (@(posedge rclk) disable iff (!mrst_n)
    rd_fire |=> (rbin == $past(rbin) + PW'(1)));

  p_wgray_one_bit_r11: assert property (@(posedge wclk) disable iff (!mrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_rgray_one_bit_r11: assert property (@(posedge rclk) disable iff (!mrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind fifo_dc fifo_dc_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .wr_commit(wr_commit),
  .rd_fire(rd_fire), .wbin(wbin), .wgray(wgray), .rbin(rbin), .rgray(rgray)
);

// File: tb/fifo_dc_bench.sv
module fifo_dc_bench;
  localparam int DEPTH = 512;
  localparam int AE_TH = 8;
  localparam int AF_TH = 8;

  logic wclk = 0, aclk = 0, async_mode = 0;
  logic rclk;
  logic mrst_n = 0, wen = 0, ren = 0, par_gen = 0, par_chk = 0;
  logic [8:0] wdata = '0;
  logic [8:0] rdata;
  logic par_err;
  logic [1:0] occ_code;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 wclk = ~wclk;
  always #17 aclk = ~aclk;
  assign rclk = async_mode ? aclk : wclk;

  fifo_dc #(.DEPTH(DEPTH), .AE_TH(AE_TH), .AF_TH(AF_TH)) u_fifo_dc (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .wen(wen), .wdata(wdata),
    .par_gen(par_gen), .ren(ren), .par_chk(par_chk), .rdata(rdata),
    .par_err(par_err), .occ_code(occ_code)
  );

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) % 512);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    mrst_n = 0; wen = 0; ren = 0;
    repeat (3) @(negedge wclk);
    mrst_n = 1;
    @(negedge wclk);
  endtask

  task automatic settle();
    repeat (12) @(negedge wclk);
  endtask

  task automatic write_run(input int first, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wen = 1; wdata = pat(first + i);
    end
    @(negedge wclk);
    wen = 0;
  endtask

  task automatic write_one(input logic [8:0] d);
    @(negedge wclk);
    wen = 1; wdata = d;
    @(negedge wclk);
    wen = 0;
  endtask

  task automatic read_run(input int first, input int n, input string req);
    @(negedge rclk);
    ren = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      if (i == n - 1) ren = 0;
      check(rdata == pat(first + i), req, int'(rdata), int'(pat(first + i)));
    end
  endtask

  task automatic read_one(output logic [8:0] d, output logic e);
    @(negedge rclk);
    ren = 1;
    @(negedge rclk);
    ren = 0;
    d = rdata; e = par_err;
  endtask

  task automatic t_reset_r1();
    mrst_n = 0;
    repeat (2) @(negedge wclk);
    check(occ_code == 2'b00, "R1 code in reset", int'(occ_code), 0);
    do_reset();
    check(occ_code == 2'b00, "R1 code", int'(occ_code), 0);
    check(par_err == 1'b0, "R1 par_err", int'(par_err), 0);
    check(rdata == 9'h000, "R1 rdata", int'(rdata), 0);
  endtask

  task automatic t_low_side_flags();
    do_reset();
    check(occ_code == 2'b00, "R5 empty", int'(occ_code), 0);
    write_run(0, 1); settle();
    check(occ_code == 2'b01, "R6 one word", int'(occ_code), 1);
    write_run(1, AE_TH - 1); settle();
    check(occ_code == 2'b01, "R6 at AE_TH", int'(occ_code), 1);
    write_run(AE_TH, 1); settle();
    check(occ_code == 2'b10, "R7 above AE_TH", int'(occ_code), 2);
    read_run(0, AE_TH + 1, "R2 burst order"); settle();
    check(occ_code == 2'b00, "R5 drained", int'(occ_code), 0);
  endtask

  task automatic t_fill_overflow();
    int lim;
    lim = DEPTH - AF_TH;
    do_reset();
    write_run(0, lim - 1); settle();
    check(occ_code == 2'b10, "R7 just below high mark", int'(occ_code), 2);
    write_run(lim - 1, 1); settle();
    check(occ_code == 2'b11, "R8 at high mark", int'(occ_code), 3);
    write_run(lim, AF_TH + 3); settle();
    check(occ_code == 2'b11, "R8 full plus ignored writes", int'(occ_code), 3);
    read_run(0, DEPTH, "R3 contents after overflow"); settle();
    check(occ_code == 2'b00, "R3 empty after DEPTH reads", int'(occ_code), 0);
  endtask

  task automatic t_underflow_r4();
    logic [8:0] d; logic e; logic [8:0] last;
    last = rdata;
    read_one(d, e);
    check(d == last, "R4 rdata held on empty read", int'(d), int'(last));
    settle();
    check(occ_code == 2'b00, "R4 still empty", int'(occ_code), 0);
    write_one(9'h0A5); settle();
    read_one(d, e);
    check(d == 9'h0A5, "R4 next word after empty read", int'(d), 'h0A5);
  endtask

  task automatic t_parity();
    logic [8:0] d; logic e;
    do_reset();
    par_gen = 1;
    write_one(9'h1FF);
    write_one(9'h001);
    par_gen = 0;
    write_one(9'h003);
    write_one(9'h007);
    write_one(9'h007);
    settle();
    par_chk = 1;
    read_one(d, e);
    check(d == 9'h0FF, "R9 generated bit8 cleared", int'(d), 'h0FF);
    check(e == 1'b0, "R10 good word", int'(e), 0);
    read_one(d, e);
    check(d == 9'h101, "R9 generated bit8 set", int'(d), 'h101);
    read_one(d, e);
    check(d == 9'h003, "R9 stored as given", int'(d), 'h003);
    check(e == 1'b0, "R10 even word", int'(e), 0);
    read_one(d, e);
    check(e == 1'b1, "R10 odd word flagged", int'(e), 1);
    par_chk = 0;
    read_one(d, e);
    check(e == 1'b0, "R10 check disabled", int'(e), 0);
  endtask

  task automatic t_async_r11();
    mrst_n = 0;
    async_mode = 1;
    do_reset();
    fork
      write_run(0, 30);
      begin
        #400;
        read_run(0, 30, "R11 async order");
      end
    join
    repeat (20) @(negedge rclk);
    check(occ_code == 2'b00, "R11 async drained", int'(occ_code), 0);
  endtask

  initial begin
    t_reset_r1();
    t_low_side_flags();
    t_fill_overflow();
    t_underflow_r4();
    t_parity();
    t_async_r11();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule